// File: doc/BRIEF.md
# Programmed-I/O Disk Write Cycle Sequencer

This block runs one programmed-I/O write transfer on the host side of a parallel disk interface. A local controller places a device address, a chip-select pattern, a 16-bit data word and six phase lengths on its inputs, then pulses `start`. The sequencer latches all of them and walks through three phases, all counted in host clock cycles. In the setup phase the address and selects are driven. In the strobe phase the active-low write strobe is low. In the hold phase the strobe is high again while the address and the data are kept for their hold times.

The data-buffer enable is switched on part-way into the strobe. This shortens the time during which the host and the device could both drive the shared lines. The device's ready line goes through a two-flop synchronizer. Once the strobe has reached a programmable check point, a low ready level stretches the strobe. A one-cycle `done` pulse closes the transfer. A `start` that arrives while a transfer is running has no effect.

Every phase-length input is 8 bits wide. A value of 0 counts as 1, so that no phase can vanish.

Top module: `pio_write_seq`

## Requirements
- R1: After an accepted `start`, `dev_cs_n` carries the inverted latched select pattern and `dev_addr` carries the latched address for exactly max(`t_setup`,1) cycles with `wr_n` high, and then `wr_n` falls.
- R2: Without ready stretching, `wr_n` stays low for exactly max(`t_strobe`,1) cycles, or longer when needed to reach max(`t_buf_on`,1)+1 or max(`t_rdy_check`,1)+1 cycles.
- R3: `rdy_in` passes through two flops. From strobe cycle max(`t_rdy_check`,1) on (counting from 0 at the first low cycle), the strobe does not end while the synchronized ready is low.
- R4: After `wr_n` rises, `dev_cs_n` stays asserted for exactly max(`t_addr_hold`,1) cycles, then goes to all ones. `dev_addr` keeps the latched value throughout.
- R5: `buf_en` rises exactly max(`t_buf_on`,1) cycles after `wr_n` falls and is never high in the setup phase.
- R6: `buf_en` stays high, with `dout` equal to the latched word, for exactly max(`t_data_hold`,1) cycles after `wr_n` rises, then falls.
- R7: `done` is high for exactly one cycle, the cycle after max(`t_addr_hold`,1, `t_data_hold`,1) hold cycles have elapsed. `busy` is low in that cycle, and a new `start` may then be accepted.
- R8: A `start` while `busy` is high is ignored. Address, selects, data and phase lengths are latched only when `start` is accepted.
- R9: During and right after reset, `wr_n` is 1, `buf_en` is 0, `done` is 0, `busy` is 0 and `dev_cs_n` is all ones.
- R10: A phase-length input of 0 behaves exactly like 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse for one write transfer |
| t_setup | input | 8 | Cycles of address setup before the strobe |
| t_strobe | input | 8 | Minimum strobe-low cycles |
| t_addr_hold | input | 8 | Cycles the address and selects are held after the strobe |
| t_data_hold | input | 8 | Cycles the data is driven after the strobe |
| t_buf_on | input | 8 | Strobe cycles before the buffer enable turns on |
| t_rdy_check | input | 8 | Strobe cycle at which ready is first examined |
| addr_in | input | 3 | Device register address |
| cs_sel | input | 2 | Active-high chip-select pattern |
| wdata_in | input | 16 | Word to write |
| rdy_in | input | 1 | Device ready line (asynchronous) |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| dev_addr | output | 3 | Device address lines |
| dev_cs_n | output | 2 | Active-low chip selects |
| wr_n | output | 1 | Active-low write strobe |
| dout | output | 16 | Write data bus |
| buf_en | output | 1 | Data buffer drive enable |

## Verification
A wrong phase or cycle count inside the block shows at the ports in the same cycle. Either `wr_n` or `buf_en` toggles one cycle early or late, or `dev_cs_n` releases at the wrong time, and the bench's per-cycle comparison reports it at once. A lost or doubled latch of the inputs shows as a wrong `dout` or `dev_addr` while the buffer or the selects are active. A fault in the ready path shows as a strobe whose length differs from the one the model derives from the two-cycle-delayed ready level.

// File: rtl/pio_pkg.sv
package pio_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;
endpackage

// File: rtl/pio_rdy_sync.sv
module pio_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign sync_out = sh_q[STAGES-1];

    // R3: the synchronized level follows the input two edges later
    p_sync_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sh_q[0]) == sh_q[STAGES-1] || STAGES != 2);
endmodule

// File: rtl/pio_time_norm.sv
module pio_time_norm #(
    parameter int TW = 8,
    parameter int N  = 6
) (
    input  logic [N*TW-1:0]     raw,
    output logic [N*(TW+1)-1:0] eff
);
    localparam int EW = TW + 1;
    for (genvar i = 0; i < N; i++) begin : g_norm
        logic [TW-1:0] v;
        assign v = raw[i*TW +: TW];
        assign eff[i*EW +: EW] = (v == '0) ? EW'(1) : {1'b0, v};
    end
endmodule

// File: rtl/pio_write_seq.sv
module pio_write_seq #(
    parameter int AW = 3,
    parameter int CW = 2,
    parameter int DW = 16,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] t_setup,
    input  logic [TW-1:0] t_strobe,
    input  logic [TW-1:0] t_addr_hold,
    input  logic [TW-1:0] t_data_hold,
    input  logic [TW-1:0] t_buf_on,
    input  logic [TW-1:0] t_rdy_check,
    input  logic [AW-1:0] addr_in,
    input  logic [CW-1:0] cs_sel,
    input  logic [DW-1:0] wdata_in,
    input  logic          rdy_in,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] dev_addr,
    output logic [CW-1:0] dev_cs_n,
    output logic          wr_n,
    output logic [DW-1:0] dout,
    output logic          buf_en
);
    import pio_pkg::*;

    localparam int NT  = 6;
    localparam int EW  = TW + 1;
    localparam int CNW = TW + 2;

    typedef struct packed {
        phase_e          phase;
        logic [CNW-1:0]  cnt;
        logic [AW-1:0]   addr;
        logic [CW-1:0]   cs;
        logic [DW-1:0]   data;
        logic [NT*TW-1:0] tim;
        logic            done;
    } st_t;

    st_t st_q, st_d;
    logic rdy_s;
    logic [NT*EW-1:0] eff;
    logic [EW-1:0] e_setup, e_strobe, e_ahold, e_dhold, e_bon, e_chk, e_hold;
    logic [CNW-1:0] cnt_inc;
    logic strobe_exit;

    pio_rdy_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(rdy_in), .sync_out(rdy_s)
    );

    pio_time_norm #(.TW(TW), .N(NT)) u_norm (.raw(st_q.tim), .eff(eff));

    assign e_setup  = eff[0*EW +: EW];
    assign e_strobe = eff[1*EW +: EW];
    assign e_ahold  = eff[2*EW +: EW];
    assign e_dhold  = eff[3*EW +: EW];
    assign e_bon    = eff[4*EW +: EW];
    assign e_chk    = eff[5*EW +: EW];
    assign e_hold   = (e_ahold > e_dhold) ? e_ahold : e_dhold;

    always_comb begin
        cnt_inc = (st_q.cnt == '1) ? st_q.cnt : st_q.cnt + 1'b1;
        strobe_exit = (st_q.cnt >= CNW'(e_strobe - 1'b1)) &&
                      (st_q.cnt >= CNW'(e_bon)) &&
                      (st_q.cnt >= CNW'(e_chk)) && rdy_s;
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_SETUP;
                    st_d.cnt   = '0;
                    st_d.addr  = addr_in;
                    st_d.cs    = cs_sel;
                    st_d.data  = wdata_in;
                    st_d.tim   = {t_rdy_check, t_buf_on, t_data_hold,
                                  t_addr_hold, t_strobe, t_setup};
                end
            end
            PH_SETUP: begin
                if (st_q.cnt >= CNW'(e_setup - 1'b1)) begin
                    st_d.phase = PH_STROBE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = cnt_inc;
                end
            end
            PH_STROBE: begin
                if (strobe_exit) begin
                    st_d.phase = PH_HOLD;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = cnt_inc;
                end
            end
            PH_HOLD: begin
                if (st_q.cnt >= CNW'(e_hold - 1'b1)) begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.cnt = cnt_inc;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, addr: '0, cs: '0,
                      data: '0, tim: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = (st_q.phase != PH_IDLE);
    assign done     = st_q.done;
    assign wr_n     = (st_q.phase != PH_STROBE);
    assign dev_addr = st_q.addr;
    assign dout     = st_q.data;
    assign buf_en   = ((st_q.phase == PH_STROBE) && (st_q.cnt >= CNW'(e_bon))) ||
                      ((st_q.phase == PH_HOLD) && (st_q.cnt < CNW'(e_dhold)));
    assign dev_cs_n = ((st_q.phase == PH_SETUP) || (st_q.phase == PH_STROBE) ||
                       ((st_q.phase == PH_HOLD) && (st_q.cnt < CNW'(e_ahold))))
                      ? ~st_q.cs : '1;

    // R7: completion pulse lasts one cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: latched transfer data stays fixed while a transfer runs
    p_latch_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(dout) || !busy);
    // R5: no buffer drive before the strobe starts
    p_no_buf_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_SETUP) |-> !buf_en);
    // R3: low synchronized ready past the check point keeps the strobe low
    p_rdy_stretch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !rdy_s && st_q.cnt >= CNW'(e_chk)) |=> !wr_n);
    // R4: selects still asserted when the strobe rises
    p_sel_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (dev_cs_n == ~st_q.cs));
    // R9: idle block never drives the strobe or buffer
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (wr_n && !buf_en));
endmodule

// File: tb/tb_pio_write_seq.sv
module tb_pio_write_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  t_setup = 0, t_strobe = 0, t_addr_hold = 0, t_data_hold = 0;
    logic [7:0]  t_buf_on = 0, t_rdy_check = 0;
    logic [2:0]  addr_in = 0;
    logic [1:0]  cs_sel = 0;
    logic [15:0] wdata_in = 0;
    logic        rdy_in = 1'b1;
    logic        busy, done, wr_n, buf_en;
    logic [2:0]  dev_addr;
    logic [1:0]  dev_cs_n;
    logic [15:0] dout;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit compare_on = 0;

    pio_write_seq dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    int m_ph = 0, m_k = 0;
    bit m_done = 0, m_s1 = 1, m_s2 = 1;
    int m_e[6];
    logic [2:0]  m_addr = 0;
    logic [1:0]  m_cs = 0;
    logic [15:0] m_data = 0;

    function automatic int nz(input logic [7:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_ph <= 0; m_k <= 0; m_done <= 0; m_s1 <= 1; m_s2 <= 1;
        end else begin
            m_s1 <= rdy_in;
            m_s2 <= m_s1;
            m_done <= 0;
            if (m_ph == 0) begin
                if (start) begin
                    m_ph <= 1; m_k <= 0;
                    m_addr <= addr_in; m_cs <= cs_sel; m_data <= wdata_in;
                    m_e[0] <= nz(t_setup);  m_e[1] <= nz(t_strobe);
                    m_e[2] <= nz(t_addr_hold); m_e[3] <= nz(t_data_hold);
                    m_e[4] <= nz(t_buf_on); m_e[5] <= nz(t_rdy_check);
                end
            end else if (m_ph == 1) begin
                if (m_k + 1 >= m_e[0]) begin m_ph <= 2; m_k <= 0; end
                else m_k <= m_k + 1;
            end else if (m_ph == 2) begin
                if (m_k + 1 >= m_e[1] && m_k >= m_e[4] && m_k >= m_e[5] && m_s2) begin
                    m_ph <= 3; m_k <= 0;
                end else m_k <= m_k + 1;
            end else begin
                if (m_k + 1 >= ((m_e[2] > m_e[3]) ? m_e[2] : m_e[3])) begin
                    m_ph <= 0; m_k <= 0; m_done <= 1;
                end else m_k <= m_k + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (compare_on) begin
            bit e_buf;
            logic [1:0] e_cs;
            e_buf = (m_ph == 2 && m_k >= m_e[4]) || (m_ph == 3 && m_k < m_e[3]);
            e_cs  = (m_ph == 1 || m_ph == 2 || (m_ph == 3 && m_k < m_e[2])) ? ~m_cs : 2'b11;
            chk("R2", "wr_n", wr_n, m_ph != 2);
            chk("R5", "buf_en", buf_en, e_buf);
            chk("R4", "dev_cs_n", dev_cs_n, e_cs);
            chk("R7", "done", done, m_done);
            chk("R8", "busy", busy, m_ph != 0);
            if (m_ph != 0) chk("R1", "dev_addr", dev_addr, m_addr);
            if (e_buf) chk("R6", "dout", dout, m_data);
        end
    end

    // independent strobe-length measurement
    int low_len = 0, last_low = 0;
    always @(posedge clk) begin
        if (!wr_n) low_len <= low_len + 1;
        else if (low_len != 0) begin last_low <= low_len; low_len <= 0; end
    end

    task automatic xfer(input int a, b, c, d, e, f, input logic [2:0] ad,
                        input logic [1:0] cs, input logic [15:0] dt, input int mid_start);
        @(negedge clk);
        t_setup = 8'(a); t_strobe = 8'(b); t_addr_hold = 8'(c);
        t_data_hold = 8'(d); t_buf_on = 8'(e); t_rdy_check = 8'(f);
        addr_in = ad; cs_sel = cs; wdata_in = dt; start = 1;
        @(negedge clk);
        start = 0;
        addr_in = ~ad; wdata_in = ~dt; t_strobe = 8'd200;
        if (mid_start > 0) begin
            repeat (mid_start) @(negedge clk);
            start = 1;
            @(negedge clk);
            start = 0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int mx(input int x, y);
        return (x > y) ? x : y;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R9", "reset wr_n", wr_n, 1);
        chk("R9", "reset buf_en", buf_en, 0);
        chk("R9", "reset done", done, 0);
        chk("R9", "reset cs", dev_cs_n, 2'b11);
        rst_n = 1;
        @(negedge clk);
        chk("R9", "post-reset busy", busy, 0);
        compare_on = 1;

        xfer(3, 6, 2, 4, 2, 3, 3'd5, 2'b01, 16'hA5C3, 0);
        chk("R2", "strobe length typical", last_low, 6);
        xfer(0, 0, 0, 0, 0, 0, 3'd2, 2'b10, 16'h1234, 0);
        chk("R10", "strobe length all-zero", last_low, 2);
        xfer(1, 3, 5, 1, 7, 2, 3'd7, 2'b11, 16'hFFFF, 0);
        chk("R2", "strobe stretched by buffer on", last_low, 8);
        xfer(2, 4, 1, 6, 1, 9, 3'd1, 2'b01, 16'h00F0, 0);
        chk("R2", "strobe stretched by check point", last_low, 10);
        // R3: ready held low across the check point
        rdy_in = 0;
        fork
            xfer(1, 3, 2, 2, 1, 2, 3'd4, 2'b10, 16'hBEEF, 0);
            begin repeat (15) @(negedge clk); rdy_in = 1; end
        join
        chk("R3", "ready stretch longer than minimum", int'(last_low > 3), 1);
        // R8: start while busy is ignored
        xfer(4, 5, 3, 2, 2, 2, 3'd6, 2'b01, 16'h5A5A, 3);
        chk("R8", "ignored start leaves one strobe", last_low, 5);
        repeat (3) @(negedge clk);
        chk("R8", "still idle after ignored start", busy, 0);
        xfer(255, 2, 255, 3, 1, 1, 3'd3, 2'b10, 16'hC001, 0);
        chk("R4", "long hold done", busy, 0);
        // back-to-back with ready toggling
        for (int i = 0; i < 8; i++) begin
            rdy_in = i[0];
            fork
                xfer(i % 3, 2 + i, mx(i, 1), 5 - i % 4, i % 4, i % 5, 3'(i), 2'(i + 1), 16'(i * 4099), 0);
                begin repeat (6 + i) @(negedge clk); rdy_in = 1; end
            join
        end
        compare_on = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    always @(negedge clk) begin
        if (cyc == 150000) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog expired actual=%0d expected=<150000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule